// File: doc/BRIEF.md
# Floating-Point Issue Interlock

This block sits between floating-point decode and a three-stage execute pipeline whose stages are, in order, multiply, add and normalize. Each cycle it judges whether the instruction on offer may enter the multiply stage. It raises `in_ready` only when that stage can accept new work and none of the instruction's registers is still waiting on an older result. The arithmetic itself is handled elsewhere. This block models only occupancy and dependencies.

The multiply stage can be held for more than one cycle. A single-precision multiplier needs two passes for a double-precision multiply. Divide, square root and reciprocal estimate iterate in place. An operand or result that is NaN or infinity costs one more cycle. The add and normalize stages always take one cycle each. Results leave the normalize stage and can be steered straight back into the multiply-stage operand latches. When that happens, the block names which of the two sources takes the forwarded value, and the wait before a dependent instruction is one cycle shorter than it would be after a register write-back. A 32-entry register scoreboard holds the pending destinations. Instructions issue strictly in program order.

Top module: `fp_issue_interlock`

## Requirements
- R1: While the multiply stage is free and no register conflict exists, `in_ready` is high, so independent single-cycle instructions are accepted on consecutive clock edges.
- R2: An instruction accepted at edge k passes through multiply, add and normalize. A single-cycle instruction reading its result is accepted no earlier than edge k+3 (two stalled cycles). At that acceptance, `fwd_a`/`fwd_b` are high for the source that matches the destination in normalize.
- R3: A double-precision multiply (op 1 with `in_dbl`=1) holds the multiply stage for two cycles, so the next independent instruction is accepted no earlier than two edges after it.
- R4: Divide (op 2) and square root (op 3) hold the multiply stage for 17 cycles, and reciprocal estimate (op 4) holds it for 4. Add is op 0, and single-precision multiply (op 1) holds for 1.
- R5: `in_special`=1 adds one cycle to the multiply-stage hold of any operation.
- R6: A consumer of a producer that holds the multiply stage for h cycles is accepted no earlier than h+2 edges after the producer.
- R7: An instruction whose destination is still pending in the scoreboard is stalled until the older writer reaches normalize.
- R8: `fwd_a`/`fwd_b` are low for a source whose producer has already left normalize, or that matches no in-flight result.
- R9: Cycles with `in_valid` low change no state. A later instruction reading the destination presented during those cycles is accepted at once.
- R10: Reset empties the pipeline model and the scoreboard. `in_ready` is high and the forward selects are low after reset, even if an instruction was in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Decoded instruction on offer |
| in_ready | output | 1 | Instruction may be accepted at this edge |
| in_op | input | 3 | Operation: 0 add, 1 multiply, 2 divide, 3 square root, 4 reciprocal estimate |
| in_dbl | input | 1 | Double precision |
| in_special | input | 1 | A NaN or infinity operand or result is involved |
| in_src_a | input | 5 | First source register |
| in_src_b | input | 5 | Second source register |
| in_dst | input | 5 | Destination register |
| fwd_a | output | 1 | First source takes the normalize-stage result |
| fwd_b | output | 1 | Second source takes the normalize-stage result |

## Verification
The bench targets the exact acceptance edge after each kind of producer. Two stalls for a chained single-cycle pair, one extra for a double multiply, sixteen behind a divide or square root, and four behind a reciprocal with a special operand. A design that clears the scoreboard too early accepts a consumer a cycle soon. One that ignores the hold counter lets a second instruction collide in the multiply stage. A chain with two producers checks that the forward flag lands on the source whose producer is in normalize, and not on one already written back. A destination reuse checks the write-after-write stall, and a reset during a divide checks that no pending state survives.

// File: rtl/fpi_pkg.sv
package fpi_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_MUL   = 3'd1,
    OP_DIV   = 3'd2,
    OP_SQRT  = 3'd3,
    OP_RECIP = 3'd4
  } fp_op_e;
endpackage

// File: rtl/fpi_stage_track.sv
// Occupancy model of multiply / add / normalize; multiply may hold for many cycles.
module fpi_stage_track #(
  parameter int RW = 5,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [CW-1:0] hold,
  input  logic [RW-1:0] dst,
  output logic          m_busy,
  output logic          a_v,
  output logic [RW-1:0] a_dst,
  output logic          n_v,
  output logic [RW-1:0] n_dst
);
  logic          m_v_q, m_v_d;
  logic [CW-1:0] m_cnt_q, m_cnt_d;
  logic [RW-1:0] m_dst_q, m_dst_d;
  logic          a_v_q, a_v_d;
  logic [RW-1:0] a_dst_q, a_dst_d;
  logic          n_v_q, n_v_d;
  logic [RW-1:0] n_dst_q, n_dst_d;
  logic          m_last;

  assign m_last = m_v_q && (m_cnt_q <= CW'(1));

  always_comb begin
    m_v_d   = m_v_q;
    m_cnt_d = m_cnt_q;
    m_dst_d = m_dst_q;
    a_v_d   = 1'b0;
    a_dst_d = a_dst_q;
    if (m_v_q) begin
      if (m_last) begin
        a_v_d   = 1'b1;
        a_dst_d = m_dst_q;
        m_v_d   = 1'b0;
      end else begin
        m_cnt_d = m_cnt_q - CW'(1);
      end
    end
    if (issue) begin
      m_v_d   = 1'b1;
      m_cnt_d = hold;
      m_dst_d = dst;
    end
    n_v_d   = a_v_q;
    n_dst_d = a_v_q ? a_dst_q : n_dst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_v_q   <= 1'b0;
      m_cnt_q <= '0;
      m_dst_q <= '0;
      a_v_q   <= 1'b0;
      a_dst_q <= '0;
      n_v_q   <= 1'b0;
      n_dst_q <= '0;
    end else begin
      m_v_q <= m_v_d;
      a_v_q <= a_v_d;
      n_v_q <= n_v_d;
      if (issue || m_v_q) m_cnt_q <= m_cnt_d;
      if (issue) m_dst_q <= m_dst_d;
      if (m_last) a_dst_q <= a_dst_d;
      if (a_v_q) n_dst_q <= n_dst_d;
    end
  end

  assign m_busy = m_v_q && !m_last;
  assign a_v    = a_v_q;
  assign a_dst  = a_dst_q;
  assign n_v    = n_v_q;
  assign n_dst  = n_dst_q;
endmodule

// File: rtl/fpi_scoreboard.sv
// One pending bit per floating-point register.
module fpi_scoreboard #(
  parameter int NREG = 32,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [RW-1:0]   set_idx,
  input  logic            clr_en,
  input  logic [RW-1:0]   clr_idx,
  output logic [NREG-1:0] pend
);
  logic [NREG-1:0] pend_q, pend_d;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      pend_d[i] = (pend_q[i] && !(clr_en && clr_idx == RW'(i)))
                || (set_en && set_idx == RW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (set_en || clr_en) pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/fpi_hazard.sv
// Structural and register-conflict check, plus forward selects.
module fpi_hazard #(
  parameter int NREG   = 32,
  parameter int RW     = 5,
  parameter bit FWD_EN = 1'b1
) (
  input  logic            valid,
  input  logic [RW-1:0]   src_a,
  input  logic [RW-1:0]   src_b,
  input  logic [RW-1:0]   dst,
  input  logic            m_busy,
  input  logic [NREG-1:0] pend,
  input  logic            n_v,
  input  logic [RW-1:0]   n_dst,
  output logic            ready,
  output logic            fwd_a,
  output logic            fwd_b
);
  logic raw, waw;

  assign raw   = pend[src_a] || pend[src_b];
  assign waw   = pend[dst];
  assign ready = !m_busy && !raw && !waw;

  generate
    if (FWD_EN) begin : g_fwd
      assign fwd_a = valid && n_v && (n_dst == src_a);
      assign fwd_b = valid && n_v && (n_dst == src_b);
    end else begin : g_nofwd
      assign fwd_a = 1'b0;
      assign fwd_b = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock #(
  parameter int NREG    = 32,
  parameter int DIV_CYC = 17,
  parameter int RCP_CYC = 4,
  parameter bit FWD_EN  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [2:0] in_op,
  input  logic       in_dbl,
  input  logic       in_special,
  input  logic [4:0] in_src_a,
  input  logic [4:0] in_src_b,
  input  logic [4:0] in_dst,
  output logic       fwd_a,
  output logic       fwd_b
);
  import fpi_pkg::*;

  localparam int RW = $clog2(NREG);
  localparam int CW = $clog2(DIV_CYC + 2);

  logic          rst_meta, rst_n_s;
  logic          iss, m_busy;
  logic [CW-1:0] hold;
  logic          a_v, n_v;
  logic [RW-1:0] a_dst, n_dst;
  logic          clr_en;
  logic [RW-1:0] clr_idx;
  logic [NREG-1:0] pend;
  fp_op_e        op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  assign op = fp_op_e'(in_op);

  always_comb begin
    unique case (op)
      OP_MUL:           hold = in_dbl ? CW'(2) : CW'(1);
      OP_DIV, OP_SQRT:  hold = CW'(DIV_CYC);
      OP_RECIP:         hold = CW'(RCP_CYC);
      default:          hold = CW'(1);
    endcase
    hold = hold + CW'(in_special);
  end

  assign iss = in_valid && in_ready;

  fpi_stage_track #(.RW(RW), .CW(CW)) u_track (
    .clk(clk), .rst_n(rst_n_s), .issue(iss), .hold(hold), .dst(in_dst[RW-1:0]),
    .m_busy(m_busy), .a_v(a_v), .a_dst(a_dst), .n_v(n_v), .n_dst(n_dst)
  );

  generate
    if (FWD_EN) begin : g_clr_early
      assign clr_en  = a_v;
      assign clr_idx = a_dst;
    end else begin : g_clr_late
      assign clr_en  = n_v;
      assign clr_idx = n_dst;
    end
  endgenerate

  fpi_scoreboard #(.NREG(NREG), .RW(RW)) u_sb (
    .clk(clk), .rst_n(rst_n_s), .set_en(iss), .set_idx(in_dst[RW-1:0]),
    .clr_en(clr_en), .clr_idx(clr_idx), .pend(pend)
  );

  fpi_hazard #(.NREG(NREG), .RW(RW), .FWD_EN(FWD_EN)) u_haz (
    .valid(in_valid), .src_a(in_src_a[RW-1:0]), .src_b(in_src_b[RW-1:0]),
    .dst(in_dst[RW-1:0]), .m_busy(m_busy), .pend(pend), .n_v(n_v), .n_dst(n_dst),
    .ready(in_ready), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );
endmodule

// File: rtl/fpi_checker.sv
module fpi_checker #(
  parameter int NREG = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [2:0]      in_op,
  input logic            in_dbl,
  input logic            in_special,
  input logic [4:0]      in_src_a,
  input logic [4:0]      in_src_b,
  input logic [4:0]      in_dst,
  input logic            fwd_a,
  input logic            fwd_b,
  input logic            m_busy,
  input logic            n_v,
  input logic [NREG-1:0] pend
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    m_busy |-> !in_ready);

  a_r3_dbl_mul_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 3'd1 && in_dbl) |=> !in_ready);

  a_r4_div_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == 3'd2 || in_op == 3'd3 || in_op == 3'd4)) |=> !in_ready);

  a_r5_special_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_special) |=> !in_ready);

  a_r6_no_raw_issue: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (!pend[in_src_a] && !pend[in_src_b]));

  a_r7_no_waw_issue: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> !pend[in_dst]);

  a_r2_pend_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> pend[$past(in_dst)]);

  a_r8_fwd_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a || fwd_b) |-> (n_v && in_valid));
endmodule

bind fp_issue_interlock fpi_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_dbl(in_dbl), .in_special(in_special),
  .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .m_busy(m_busy), .n_v(n_v), .pend(pend)
);

// File: tb/fp_issue_interlock_test.sv
`timescale 1ns/1ps
module fp_issue_interlock_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_dbl, in_special;
  logic [2:0] in_op;
  logic [4:0] in_src_a, in_src_b, in_dst;
  logic       in_ready, fwd_a, fwd_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp_issue_interlock uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dbl(in_dbl), .in_special(in_special),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  // op, dbl, special, src_a, src_b, dst, expected stall cycles, expected {fwd_a,fwd_b}
  localparam int NV = 14;
  localparam logic [26:0] VEC [NV] = '{
    {3'd0,1'b0,1'b0,5'd1, 5'd2, 5'd3, 5'd0, 2'b00}, // R1 first
    {3'd0,1'b0,1'b0,5'd4, 5'd5, 5'd6, 5'd0, 2'b00}, // R1 back to back
    {3'd1,1'b0,1'b0,5'd3, 5'd7, 5'd8, 5'd1, 2'b10}, // R2 reads row 1
    {3'd0,1'b0,1'b0,5'd8, 5'd0, 5'd9, 5'd2, 2'b10}, // R2 chained
    {3'd1,1'b1,1'b0,5'd10,5'd11,5'd12,5'd0, 2'b00}, // R3 double mul
    {3'd0,1'b0,1'b0,5'd13,5'd14,5'd15,5'd1, 2'b00}, // R3 blocked one cycle
    {3'd0,1'b0,1'b0,5'd12,5'd14,5'd16,5'd1, 2'b10}, // R6 consumer of h=2
    {3'd2,1'b0,1'b0,5'd17,5'd19,5'd18,5'd0, 2'b00}, // R4 divide
    {3'd0,1'b0,1'b0,5'd19,5'd20,5'd21,5'd16,2'b00}, // R4 behind divide
    {3'd0,1'b0,1'b0,5'd18,5'd21,5'd22,5'd2, 2'b01}, // R6 R8 two producers
    {3'd4,1'b0,1'b1,5'd23,5'd0, 5'd24,5'd0, 2'b00}, // R5 reciprocal special
    {3'd3,1'b0,1'b0,5'd25,5'd0, 5'd26,5'd4, 2'b00}, // R4 R5 hold 5
    {3'd0,1'b0,1'b1,5'd1, 5'd2, 5'd27,5'd16,2'b00}, // R4 behind sqrt
    {3'd0,1'b0,1'b0,5'd4, 5'd5, 5'd27,5'd3, 2'b00}  // R7 same destination
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic present(input logic [2:0] op, input logic dbl, input logic spc,
                         input logic [4:0] sa, input logic [4:0] sb, input logic [4:0] d,
                         output int waits, output logic [1:0] fw);
    in_valid = 1'b1; in_op = op; in_dbl = dbl; in_special = spc;
    in_src_a = sa; in_src_b = sb; in_dst = d;
    waits = 0;
    #1;
    while (!in_ready && waits < 40) begin
      @(negedge clk); #1;
      waits++;
    end
    fw = {fwd_a, fwd_b};
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w;
    logic [1:0] fw;
    rst_n = 1'b0; in_valid = 1'b0; in_op = 3'd0; in_dbl = 1'b0; in_special = 1'b0;
    in_src_a = 5'd0; in_src_b = 5'd0; in_dst = 5'd0;
    repeat (3) @(negedge clk);
    check("R10 ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 ready after reset", int'(in_ready), 1);
    check("R10 forward idle", int'({fwd_a, fwd_b}), 0);

    for (int i = 0; i < NV; i++) begin
      present(VEC[i][26:24], VEC[i][23], VEC[i][22], VEC[i][21:17], VEC[i][16:12],
              VEC[i][11:7], w, fw);
      check($sformatf("R1-R7 row %0d stall", i), w, int'(VEC[i][6:2]));
      check($sformatf("R2 R8 row %0d forward", i), int'(fw), int'(VEC[i][1:0]));
    end

    // R9: nothing offered for several cycles with destination 31 on the bus
    in_valid = 1'b0; in_op = 3'd2; in_dst = 5'd31; in_src_a = 5'd31; in_src_b = 5'd31;
    repeat (6) @(negedge clk);
    present(3'd0, 1'b0, 1'b0, 5'd31, 5'd31, 5'd30, w, fw);
    check("R9 invalid cycles leave no pending state", w, 0);

    // R10: reset in the middle of a divide
    present(3'd2, 1'b0, 1'b0, 5'd1, 5'd2, 5'd5, w, fw);
    in_valid = 1'b0;
    #1;
    check("R4 divide holds multiply stage", int'(in_ready), 0);
    rst_n = 1'b0;
    #1;
    check("R10 async clear of occupancy", int'(in_ready), 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    present(3'd0, 1'b0, 1'b0, 5'd5, 5'd5, 5'd6, w, fw);
    check("R10 scoreboard cleared by reset", w, 0);
    check("R10 no forward after reset", int'(fw), 0);

    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule